// File: doc/BRIEF.md
# Variable-Length Serial Register Loader

This block is the write-only serial front end of a pulse generator. A host drives a chip select (active low), a serial clock that idles low, and a data line. While the select is low, the block samples one data bit on every rising serial-clock edge, most significant bit first. When the select rises, the block counts the bits it received and decides which of three 8-bit settings to update: the control byte, the period byte and the high-time byte. It then issues a one-cycle commit strobe so that the pulse core can take the new values at the end of its current period.

The length of the write picks its target. A full 24-bit write sets control, period and high time, in that order on the wire. A 16-bit write sets period and high time. An 8-bit write sets only the high time. Any other length is dropped. The control byte holds a clock-halving bit and a power-down bit. It also decides whether the pulse core may run: the core is held off until the first full write has been accepted, and it is held off again for as long as power-down is set. The three serial inputs are brought into the system clock domain through a configurable synchronizer chain.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset, all four settings read zero, and the initialized, run and commit outputs are low.
- R2: Bits are sampled on rising serial-clock edges while select is low, most significant bit first. A 24-bit write loads the first byte into control, the second into period and the third into high time.
- R3: A 16-bit write loads its first byte into period and its second into high time. The control fields are unchanged.
- R4: An 8-bit write loads only the high-time byte. Control and period are unchanged.
- R5: A write of any length other than 8, 16 or 24 bits, including 0 and anything longer than 24, changes nothing and produces no commit.
- R6: Each accepted write produces exactly one commit pulse, one system clock wide, after select rises.
- R7: In the control byte, bit 0 sets the divide-by-two output and bit 2 sets the power-down output. Bits 1 and 3 to 7 affect no output.
- R8: The initialized output rises on the first accepted 24-bit write and then stays high until reset. The run output is high exactly when the block is initialized and power-down is clear.
- R9: While power-down is set, 8-bit and 16-bit writes still update their bytes, but run stays low. Only a 24-bit write with bit 2 clear brings run back.
- R10: Serial-clock edges while select is high neither shift nor count. A following write is decoded as if those edges never happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data, sampled on rising sck_i |
| csn_i | input | 1 | Select, active low; its rising edge ends a write |
| div2_o | output | 1 | Divide-by-two setting from control bit 0 |
| pwrdn_o | output | 1 | Power-down setting from control bit 2 |
| period_o | output | 8 | Period byte |
| high_o | output | 8 | High-time byte |
| commit_o | output | 1 | One-cycle strobe after an accepted write |
| init_o | output | 1 | Set by the first accepted 24-bit write |
| run_o | output | 1 | Pulse core enable |

## Verification
Write lengths from 0 to 30 bits are swept, each carrying a distinct computed bit pattern. Lengths 7, 9, 15, 17, 23 and 25 sit next to the valid ones and would expose a counter that is off by one or that wraps. Walking-one and all-ones control bytes separate the two live control bits from the ignored ones. A sequence that enters power-down, sends short writes and then leaves power-down with a full write tells storing a byte apart from enabling the output. Clock pulses sent while the select is high, followed by a normal write, show whether idle edges leak into the shift or the count.

// File: rtl/srl_pkg.sv
package srl_pkg;
    parameter int REG_W  = 8;
    parameter int DIV_BIT = 0;
    parameter int PD_BIT  = 2;
    localparam int FULL_BITS = 3 * REG_W;
    // ignored control bits above PD_BIT are never stored
    localparam int SR_W  = FULL_BITS - (REG_W - 1 - PD_BIT);
    localparam int CNT_W = $clog2(FULL_BITS + 2);
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] chain_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) chain_q[i] <= rst_val;
                end else begin
                    chain_q[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
                end
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/srl_frontend.sv
module srl_frontend
    import srl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             sdi_s,
    input  logic             csn_s,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             fld_div_o,
    output logic             fld_pd_o,
    output logic [REG_W-1:0] fld_per_o,
    output logic [REG_W-1:0] fld_hi_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FULL_BITS + 1);

    typedef struct packed {
        logic            sck_prev;
        logic            csn_prev;
        logic [SR_W-1:0] sr;
        logic [CNT_W-1:0] cnt;
    } fe_state_t;

    fe_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.sck_prev = sck_s;
        st_d.csn_prev = csn_s;
        if (!csn_s && st_q.csn_prev) begin
            st_d.sr  = '0;
            st_d.cnt = '0;
        end else if (!csn_s && sck_s && !st_q.sck_prev) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdi_s};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sck_prev: 1'b0, csn_prev: 1'b1, sr: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o    = csn_s && !st_q.csn_prev;
    assign count_o   = st_q.cnt;
    assign fld_hi_o  = st_q.sr[REG_W-1:0];
    assign fld_per_o = st_q.sr[2*REG_W-1:REG_W];
    assign fld_div_o = st_q.sr[2*REG_W+DIV_BIT];
    assign fld_pd_o  = st_q.sr[SR_W-1];

    // R10: a deselected interface must not count
    assert_idle_no_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && st_q.csn_prev) |=> $stable(st_q.cnt));
    // R5: the counter never passes its saturation value
    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SAT);
endmodule

// File: rtl/srl_decoder.sv
module srl_decoder
    import srl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             fld_div_i,
    input  logic             fld_pd_i,
    input  logic [REG_W-1:0] fld_per_i,
    input  logic [REG_W-1:0] fld_hi_i,
    output logic             div2_o,
    output logic             pwrdn_o,
    output logic [REG_W-1:0] period_o,
    output logic [REG_W-1:0] high_o,
    output logic             commit_o,
    output logic             init_o,
    output logic             run_o
);
    typedef struct packed {
        logic             div;
        logic             pd;
        logic [REG_W-1:0] per;
        logic [REG_W-1:0] hi;
        logic             init;
        logic             commit;
    } dec_state_t;

    dec_state_t st_q, st_d;

    logic len_one, len_two, len_full;
    assign len_one  = (count_i == CNT_W'(REG_W));
    assign len_two  = (count_i == CNT_W'(2 * REG_W));
    assign len_full = (count_i == CNT_W'(FULL_BITS));

    always_comb begin
        st_d = st_q;
        st_d.commit = 1'b0;
        if (done_i && (len_one || len_two || len_full)) begin
            st_d.commit = 1'b1;
            st_d.hi     = fld_hi_i;
            if (len_two || len_full) st_d.per = fld_per_i;
            if (len_full) begin
                st_d.div  = fld_div_i;
                st_d.pd   = fld_pd_i;
                st_d.init = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div2_o   = st_q.div;
    assign pwrdn_o  = st_q.pd;
    assign period_o = st_q.per;
    assign high_o   = st_q.hi;
    assign commit_o = st_q.commit;
    assign init_o   = st_q.init;
    assign run_o    = st_q.init && !st_q.pd;

    // R6: strobe lasts one cycle
    assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    // R5: a bad length yields no strobe
    assert_bad_len_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !len_one && !len_two && !len_full) |=> !commit_o);
    // R3: control fields move only on a full write
    assert_ctrl_full_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !len_full) |=> ($stable(div2_o) && $stable(pwrdn_o)));
    // R8: initialization is sticky
    assert_init_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> init_o);
    // R9: never run while powered down
    assert_no_run_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_o |-> !run_o);
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
    import srl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_i,
    input  logic             sdi_i,
    input  logic             csn_i,
    output logic             div2_o,
    output logic             pwrdn_o,
    output logic [REG_W-1:0] period_o,
    output logic [REG_W-1:0] high_o,
    output logic             commit_o,
    output logic             init_o,
    output logic             run_o
);
    logic [2:0]       sync_q;
    logic             done;
    logic [CNT_W-1:0] count;
    logic             f_div, f_pd;
    logic [REG_W-1:0] f_per, f_hi;

    srl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(3'b100),
        .d_i({csn_i, sdi_i, sck_i}), .q_o(sync_q)
    );

    srl_frontend i_fe (
        .clk(clk), .rst_n(rst_n),
        .sck_s(sync_q[0]), .sdi_s(sync_q[1]), .csn_s(sync_q[2]),
        .done_o(done), .count_o(count),
        .fld_div_o(f_div), .fld_pd_o(f_pd), .fld_per_o(f_per), .fld_hi_o(f_hi)
    );

    srl_decoder i_dec (
        .clk(clk), .rst_n(rst_n), .done_i(done), .count_i(count),
        .fld_div_i(f_div), .fld_pd_i(f_pd), .fld_per_i(f_per), .fld_hi_i(f_hi),
        .div2_o(div2_o), .pwrdn_o(pwrdn_o), .period_o(period_o), .high_o(high_o),
        .commit_o(commit_o), .init_o(init_o), .run_o(run_o)
    );
endmodule

// File: tb/test_serial_reg_loader.sv
module test_serial_reg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b1;
    logic div2, pwrdn, commit, init, run;
    logic [7:0] period, high;

    int tests = 0, fails = 0, commits = 0, wide = 0;
    logic commit_prev = 1'b0;

    // expected model
    logic e_div = 0, e_pd = 0, e_init = 0;
    logic [7:0] e_per = 0, e_hi = 0;
    int e_commits = 0;

    always #10 clk = ~clk;

    serial_reg_loader i_serial_reg_loader (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
        .div2_o(div2), .pwrdn_o(pwrdn), .period_o(period), .high_o(high),
        .commit_o(commit), .init_o(init), .run_o(run)
    );

    always @(posedge clk) begin
        if (commit) commits++;
        if (commit && commit_prev) wide++;
        commit_prev <= commit;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xfer(input int n, input logic [31:0] bits);
        csn = 1'b0; wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i]; wait_clk(4);
            sck = 1'b1;    wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        csn = 1'b1; wait_clk(10);
        if (n == 24) begin
            e_div = bits[16]; e_pd = bits[18]; e_init = 1'b1;
        end
        if (n == 24 || n == 16) e_per = bits[15:8];
        if (n == 24 || n == 16 || n == 8) begin
            e_hi = bits[7:0]; e_commits++;
        end
    endtask

    task automatic check_all(input string req);
        chk(req, high, e_hi);
        chk(req, period, e_per);
        chk(req, div2, e_div);
        chk(req, pwrdn, e_pd);
        chk(req, init, e_init);
        chk(req, run, e_init && !e_pd);
        chk(req, commits, e_commits);
    endtask

    initial begin : watchdog
        #3000000;
        fails++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait_clk(5);
        // R1 reset state
        check_all("R1");
        chk("R1", commit, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R4 before init: stored but no run (R8)
        xfer(8, 32'h5A);
        check_all("R4/R8");

        // R5 length sweep 0..30 with distinct patterns, control bit2 kept 0
        for (int n = 0; n <= 30; n++) begin
            logic [31:0] p;
            p = (32'h9E37_79B9 * (n + 3)) ^ 32'h00C3_A5F0;
            p[18] = 1'b0;
            xfer(n, p);
            if (n == 24) check_all("R2");
            else if (n == 16) check_all("R3");
            else if (n == 8) check_all("R4");
            else check_all("R5");
        end

        // R7 walking control bits
        for (int b = 0; b < 8; b++) begin
            xfer(24, {8'h00, 8'(1 << b), 8'(b * 29 + 1), 8'(b * 13 + 7)});
            check_all("R7");
        end
        xfer(24, 32'h00FB_1122);
        check_all("R7");

        // R9 power-down sequence
        xfer(24, 32'h0004_3344);
        check_all("R9");
        xfer(8, 32'h77);
        check_all("R9");
        xfer(16, 32'h8899);
        check_all("R9");
        xfer(24, 32'h00FB_A0B0);
        check_all("R9");

        // R10 clocks while deselected, then an 8-bit write
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1; wait_clk(4); sck = 1'b1; wait_clk(4); sck = 1'b0;
        end
        wait_clk(10);
        check_all("R10");
        xfer(8, 32'h3C);
        check_all("R10");

        // high-time sweep over 8-bit writes
        for (int v = 0; v < 256; v += 17) begin
            xfer(8, 32'(v));
            check_all("R4");
        end

        // R6 pulse width
        chk("R6", wide, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule